// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Interrupt Aggregation

This block is a general-purpose I/O controller for 1 to 32 pins. It sits behind a small 32-bit register bus with a word address, a write strobe with write data, and a read strobe with registered read data. Software uses it to drive output values, to choose which pins are outputs, to read the pin levels, and to take one interrupt when selected pins show activity.

Every pin input passes through a two-stage synchroniser. The trigger style is fixed when the block is built, using the `TRIGGER` parameter: rising edge, falling edge, either edge, or high level. In the three edge styles, a qualifying transition latches a bit in a capture register. Software clears that bit by writing a one to it. In the level style, the pending status is the synchronised input ANDed with the enable mask, so it clears itself when the pin goes low. One interrupt output is the OR of all enabled pending bits. Separate set and clear registers change output bits without a read-modify-write.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, the output latch, the direction register, the interrupt enable mask and the capture register are zero, `pin_out` and `pin_oe` are zero, and `irq` is low.
- R2: A write to word index 0 loads the output latch, which drives `pin_out`. A read of index 0 returns `pin_in` after the two-stage synchroniser. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`.
- R3: Index 1 is the direction register. Bit value 1 makes the pin an output, and `pin_oe` equals this register. It reads back as written.
- R4: A write to index 4 ORs the written ones into the output latch. A write to index 5 clears the written ones from the latch. Both indices read as zero.
- R5: When TRIGGER is rising, only a 0-to-1 transition of a synchronised pin sets its bit in the capture register (index 3).
- R6: When TRIGGER is falling, only a 1-to-0 transition sets the capture bit.
- R7: When TRIGGER is both, any transition sets the capture bit.
- R8: In the edge styles, writing 1 to a capture bit clears it and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as a clear, the bit stays set.
- R9: Index 2 is the interrupt enable mask, where 1 enables a pin. In the edge styles, `irq` is high exactly when some captured bit is also enabled. A disabled bit stays captured but does not raise `irq`.
- R10: When TRIGGER is level, `irq` is high while any synchronised input that is high is also enabled. Index 3 then reads that masked input vector, and writes to index 3 have no effect.
- R11: Bits at and above N_PINS read as zero, and writes to them are ignored.
- R12: Word indices 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | N_PINS | Pin levels from the pads |
| pin_out | output | N_PINS | Output latch value |
| pin_oe | output | N_PINS | Output enable for each pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that read and write strobes are single-cycle pulses with a stable address during each pulse. They also assume that pins do not change faster than the synchroniser can follow. The bench drives every bus and pin input at the falling clock edge. It changes pins only in steps that are several cycles apart, and it sets up the one same-cycle edge-versus-clear collision by counting synchroniser stages. Capture registers are cleared after each pin pattern that creates edges, so each later scenario starts from a known pending state.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    // word indices of the register map
    localparam logic [ADDR_W-1:0] IDX_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_CAP  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_SET  = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_CLR  = 3'd5;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int    W       = 32,
    parameter trig_e TRIGGER = TRIG_RISE
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    output logic [W-1:0] evt_o
);

    generate
        if (TRIGGER == TRIG_RISE) begin : g_rise
            assign evt_o = sync_i & ~prev_i;
        end else if (TRIGGER == TRIG_FALL) begin : g_fall
            assign evt_o = ~sync_i & prev_i;
        end else if (TRIGGER == TRIG_BOTH) begin : g_both
            assign evt_o = sync_i ^ prev_i;
        end else begin : g_level
            logic unused_lvl;
            assign unused_lvl = ^{sync_i, prev_i};
            assign evt_o      = '0;
        end
    endgenerate

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] cap_o
);

    typedef struct packed {
        logic [W-1:0] cap;
    } cap_t;

    cap_t st_d, st_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask   = clr_we_i ? clr_bits_i : '0;
        st_d       = st_q;
        // a fresh event takes priority over a clear in the same cycle
        st_d.cap   = (st_q.cap & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_o = st_q.cap;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic [W-1:0]      sync_i,
    input  logic [W-1:0]      cap_view_i,
    output logic              cap_clr_o,
    output logic [W-1:0]      out_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      mask_o,
    output logic [BUS_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [W-1:0]     out;
        logic [W-1:0]     dir;
        logic [W-1:0]     mask;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [W-1:0] wbits;

    always_comb begin
        wbits     = bus_wdata[W-1:0];
        st_d      = st_q;
        cap_clr_o = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                IDX_DATA: st_d.out  = wbits;
                IDX_DIR:  st_d.dir  = wbits;
                IDX_MASK: st_d.mask = wbits;
                IDX_CAP:  cap_clr_o = 1'b1;
                IDX_SET:  st_d.out  = st_q.out | wbits;
                IDX_CLR:  st_d.out  = st_q.out & ~wbits;
                default:  ;
            endcase
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            case (bus_addr)
                IDX_DATA: st_d.rdata[W-1:0] = sync_i;
                IDX_DIR:  st_d.rdata[W-1:0] = st_q.dir;
                IDX_MASK: st_d.rdata[W-1:0] = st_q.mask;
                IDX_CAP:  st_d.rdata[W-1:0] = cap_view_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o   = st_q.out;
    assign dir_o   = st_q.dir;
    assign mask_o  = st_q.mask;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter int    N_PINS  = 32,
    parameter trig_e TRIGGER = TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    localparam bit IS_LEVEL = (TRIGGER == TRIG_LEVEL);

    logic [N_PINS-1:0] sync_w, prev_w, evt_w, cap_w, mask_w;
    logic [N_PINS-1:0] cap_view_w, pend_w;
    logic              cap_clr_w;

    gpio_pin_sync #(.W(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_w),
        .prev_o (prev_w)
    );

    gpio_edge_detect #(.W(N_PINS), .TRIGGER(TRIGGER)) u_edge (
        .sync_i (sync_w),
        .prev_i (prev_w),
        .evt_o  (evt_w)
    );

    gpio_capture #(.W(N_PINS)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .clr_we_i   (cap_clr_w),
        .clr_bits_i (bus_wdata[N_PINS-1:0]),
        .cap_o      (cap_w)
    );

    gpio_regs #(.W(N_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .sync_i     (sync_w),
        .cap_view_i (cap_view_w),
        .cap_clr_o  (cap_clr_w),
        .out_o      (pin_out),
        .dir_o      (pin_oe),
        .mask_o     (mask_w),
        .rdata_o    (bus_rdata)
    );

    generate
        if (IS_LEVEL) begin : g_level_src
            logic unused_cap;
            assign unused_cap = ^cap_w;
            assign cap_view_w = sync_w & mask_w;
            assign pend_w     = cap_view_w;
        end else begin : g_edge_src
            assign cap_view_w = cap_w;
            assign pend_w     = cap_w & mask_w;
        end
    endgenerate

    assign irq = |pend_w;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int    N_PINS  = 32,
    parameter trig_e TRIGGER = TRIG_RISE
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] mask_q,
    input logic [N_PINS-1:0] cap_q,
    input logic [N_PINS-1:0] edge_evt
);

    // R1: held reset gives cleared outputs on the following edge
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && !irq));

    // R3: direction only moves on a bus write
    a_r3_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_oe));

    // R4: set register forces the written ones high
    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_SET) |=>
        ((pin_out & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

    // R4: clear register forces the written ones low
    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_CLR) |=>
        ((pin_out & $past(bus_wdata[N_PINS-1:0])) == '0));

    // R9: nothing enabled means no request
    a_r9_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    generate
        if (TRIGGER != TRIG_LEVEL) begin : g_edge_props
            // R8: an event always leaves its capture bit set, even against a clear
            a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_evt != '0) |=> ((cap_q & $past(edge_evt)) == $past(edge_evt)));

            // R8: write-one clears bits that saw no new event
            a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == IDX_CAP && edge_evt == '0) |=>
                ((cap_q & $past(bus_wdata[N_PINS-1:0])) == '0));

            // R9: a request implies some captured bit
            a_r9_irq_has_cap: assert property (@(posedge clk) disable iff (!rst_n)
                irq |-> (cap_q != '0));
        end
    endgenerate

endmodule

bind gpio_irq_top gpio_irq_chk #(.N_PINS(N_PINS), .TRIGGER(TRIGGER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mask_q    (mask_w),
    .cap_q     (cap_w),
    .edge_evt  (evt_w)
);

// File: tb/tb_gpio_irq_top.sv
module tb_gpio_irq_top;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_PINS   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] pin_in = '0;

    logic [31:0] rd_rise, rd_fall, rd_both, rd_lvl;
    logic [31:0] po_rise, po_fall, po_both;
    logic [31:0] oe_rise, oe_fall, oe_both;
    logic [LVL_PINS-1:0] po_lvl, oe_lvl;
    logic irq_rise, irq_fall, irq_both, irq_lvl;

    logic [31:0] v_rise, v_fall, v_both, v_lvl;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_top #(.N_PINS(32), .TRIGGER(TRIG_RISE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd_rise),
        .pin_in(pin_in), .pin_out(po_rise), .pin_oe(oe_rise), .irq(irq_rise));

    gpio_irq_top #(.N_PINS(32), .TRIGGER(TRIG_FALL)) dut_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd_fall),
        .pin_in(pin_in), .pin_out(po_fall), .pin_oe(oe_fall), .irq(irq_fall));

    gpio_irq_top #(.N_PINS(32), .TRIGGER(TRIG_BOTH)) dut_both (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd_both),
        .pin_in(pin_in), .pin_out(po_both), .pin_oe(oe_both), .irq(irq_both));

    gpio_irq_top #(.N_PINS(LVL_PINS), .TRIGGER(TRIG_LEVEL)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rd_lvl),
        .pin_in(pin_in[LVL_PINS-1:0]), .pin_out(po_lvl), .pin_oe(oe_lvl), .irq(irq_lvl));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = idx;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx);
        @(negedge clk);
        bus_addr = idx;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        v_rise = rd_rise;
        v_fall = rd_fall;
        v_both = rd_both;
        v_lvl  = rd_lvl;
    endtask

    task automatic set_pins(input logic [31:0] val);
        @(negedge clk);
        pin_in = val;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pin_out", po_rise, 32'h0);
        chk("R1 pin_oe", oe_rise, 32'h0);
        chk("R1 irq", {28'h0, irq_rise, irq_fall, irq_both, irq_lvl}, 32'h0);
        bus_read(IDX_MASK);
        chk("R1 mask", v_rise, 32'h0);
        bus_read(IDX_CAP);
        chk("R1 capture", v_both, 32'h0);
    endtask

    task automatic t_data_dir;
        bus_write(IDX_DATA, 32'hA5A5_0F0F);
        chk("R2 data write to pin_out", po_rise, 32'hA5A5_0F0F);
        bus_write(IDX_DIR, 32'hFFFF_0000);
        chk("R3 pin_oe", oe_rise, 32'hFFFF_0000);
        bus_read(IDX_DIR);
        chk("R3 dir readback", v_rise, 32'hFFFF_0000);
        set_pins(32'h1234_5678);
        bus_read(IDX_DATA);
        chk("R2 data read of pins", v_rise, 32'h1234_5678);
        set_pins(32'h0);
        bus_write(IDX_CAP, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_clear;
        bus_write(IDX_DATA, 32'h0000_00F0);
        bus_write(IDX_SET, 32'h0F00_000F);
        chk("R4 set", po_rise, 32'h0F00_00FF);
        bus_write(IDX_CLR, 32'h0F00_0010);
        chk("R4 clear", po_rise, 32'h0000_00EF);
        bus_read(IDX_SET);
        chk("R4 set reads zero", v_rise, 32'h0);
        bus_read(IDX_CLR);
        chk("R4 clear reads zero", v_rise, 32'h0);
    endtask

    task automatic t_map;
        bus_read(3'd6);
        chk("R12 index 6", v_rise, 32'h0);
        bus_read(3'd7);
        chk("R12 index 7", v_rise, 32'h0);
    endtask

    task automatic t_edges;
        set_pins(32'h3);
        bus_read(IDX_CAP);
        chk("R5 rise captures", v_rise, 32'h3);
        chk("R6 fall ignores rise", v_fall, 32'h0);
        chk("R7 both captures rise", v_both, 32'h3);
        chk("R9 masked off no irq", {29'h0, irq_rise, irq_fall, irq_both}, 32'h0);
        set_pins(32'h1);
        bus_read(IDX_CAP);
        chk("R5 rise ignores fall", v_rise, 32'h3);
        chk("R6 fall captures", v_fall, 32'h2);
        chk("R7 both captures fall", v_both, 32'h3);
        bus_write(IDX_MASK, 32'h2);
        chk("R9 enabled irq", {29'h0, irq_rise, irq_fall, irq_both}, 32'h7);
        bus_write(IDX_CAP, 32'h0);
        bus_read(IDX_CAP);
        chk("R8 write zero keeps", v_rise, 32'h3);
        bus_write(IDX_CAP, 32'h2);
        bus_read(IDX_CAP);
        chk("R8 write one clears", v_rise, 32'h1);
        chk("R8 write one clears fall", v_fall, 32'h0);
        chk("R9 disabled bit no irq", {29'h0, irq_rise, irq_fall, irq_both}, 32'h0);
        bus_write(IDX_CAP, 32'hFFFF_FFFF);
    endtask

    task automatic t_collision;
        // bit 2 rises; its event reaches the capture input two edges later
        @(negedge clk);
        pin_in = 32'h5;
        @(negedge clk);
        @(negedge clk);
        bus_addr  = IDX_CAP;
        bus_wdata = 32'h4;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_read(IDX_CAP);
        chk("R8 edge beats clear", v_rise, 32'h4);
        bus_write(IDX_CAP, 32'hFFFF_FFFF);
    endtask

    task automatic t_level;
        bus_write(IDX_MASK, 32'h4);
        chk("R10 level irq", {31'h0, irq_lvl}, 32'h1);
        bus_read(IDX_CAP);
        chk("R10 pending view", v_lvl, 32'h4);
        bus_write(IDX_CAP, 32'hFFFF_FFFF);
        bus_read(IDX_CAP);
        chk("R10 capture write ignored", v_lvl, 32'h4);
        set_pins(32'h1);
        chk("R10 irq drops with pin", {31'h0, irq_lvl}, 32'h0);
        set_pins(32'h5);
        chk("R10 irq returns with pin", {31'h0, irq_lvl}, 32'h1);
        bus_write(IDX_MASK, 32'h0);
        chk("R10 irq drops with mask", {31'h0, irq_lvl}, 32'h0);
        bus_write(IDX_CAP, 32'hFFFF_FFFF);
    endtask

    task automatic t_width;
        bus_write(IDX_DIR, 32'hFFFF_FFFF);
        bus_read(IDX_DIR);
        chk("R11 dir upper bits", v_lvl, 32'h0000_001F);
        chk("R11 pin_oe width", {27'h0, oe_lvl}, 32'h0000_001F);
        bus_write(IDX_MASK, 32'hFFFF_FFE0);
        bus_read(IDX_MASK);
        chk("R11 mask upper ignored", v_lvl, 32'h0);
        set_pins(32'hFFFF_FFFF);
        bus_read(IDX_DATA);
        chk("R11 data upper bits", v_lvl, 32'h0000_001F);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_dir();
        t_set_clear();
        t_map();
        t_edges();
        t_collision();
        t_level();
        t_width();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule